// File: doc/BRIEF.md
# Safeload Parameter Transfer Controller

This block keeps a small bank of staging slots. Each slot holds one parameter RAM address and one data word. A host fills the slots through a simple write strobe. The host then asks for a transfer by setting the transfer bit in a control word. From then on the block waits for the next audio frame strobe. At that strobe it copies every slot written since the last transfer into the parameter RAM through a single write port, one word per clock. Because the copy starts on a frame boundary, the DSP reading the RAM never sees a coefficient set that is only partly updated.

Slots the host has not written since the last transfer produce no RAM write. When the last pending slot is committed, a completion flag rises. The flag stays up until the host reads it, and the read clears it. While a transfer is pending or running, the block raises a busy output and ignores host writes to the slots.

Top module: `safeload_ctrl`

## Requirements
- R1: While `busy_o` is low, a pulse on `slot_we_i` stores `slot_addr_i`/`slot_data_i` into the slot numbered `slot_sel_i` and marks that slot pending. A later write to the same slot replaces the pair and still gives a single RAM write. A value of `slot_sel_i` of NUM_SLOTS or more stores nothing and marks nothing pending.
- R2: While `busy_o` is low, a cycle with `ctrl_we_i` high and `ctrl_wdata_i` bit 9 equal to 1 requests a transfer, and `busy_o` is high from the next cycle on. A control write with bit 9 equal to 0 has no effect.
- R3: The copy waits for the first `frame_sync_i` pulse sampled on a clock edge after the request edge. A strobe in the request cycle itself does not start it. `ram_we_o` stays low until that edge.
- R4: From the frame edge on, `ram_we_o` is high for one cycle per pending slot. The cycles are consecutive and go in ascending slot number. `ram_addr_o`/`ram_data_o` carry that slot's stored pair.
- R5: Each slot stops being pending once it is copied. A new request with no new host writes produces no RAM writes.
- R6: `done_o` rises, and `busy_o` falls, on the same edge that commits the last RAM write.
- R7: If nothing is pending, `done_o` rises and `busy_o` falls on the frame strobe edge, with no RAM write.
- R8: `stat_re_i` high for a cycle clears `done_o` on that edge. If completion happens on the same edge, `done_o` stays set.
- R9: A host slot write while `busy_o` is high is ignored. It marks no slot pending and leads to no RAM write, either in the current transfer or in the next one.
- R10: Reset (active-low, asynchronous) clears all pending marks, `done_o`, `busy_o` and `ram_we_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_we_i | input | 1 | Host slot write strobe |
| slot_sel_i | input | SEL_W | Slot number to write |
| slot_addr_i | input | ADDR_W | Parameter RAM address for the slot |
| slot_data_i | input | DATA_W | Parameter data for the slot |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | CTRL_W | Control word; bit 9 requests a transfer |
| frame_sync_i | input | 1 | Audio frame boundary strobe |
| stat_re_i | input | 1 | Status read strobe; clears the completion flag |
| done_o | output | 1 | Transfer complete flag |
| busy_o | output | 1 | Transfer pending or active; slot writes ignored |
| ram_we_o | output | 1 | Parameter RAM write enable |
| ram_addr_o | output | ADDR_W | Parameter RAM write address |
| ram_data_o | output | DATA_W | Parameter RAM write data |

## Verification
The bench uses the default parameters: 5 slots, 10-bit addresses, 26-bit data and a 12-bit control word. With 5 slots the select field is 3 bits wide, so the values 5 to 7 can be driven, and the bench uses them to check that an out-of-range select writes nothing. With 5 slots, a full bank gives a five-write burst, and sparse patterns make the scan skip clean slots in the middle of the bank and at its top. The 26-bit data width lets the bench use distinct data values that catch a mix-up between address and data fields or between neighbouring slots.

// File: rtl/safeload_pkg.sv
package safeload_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ARMED = 2'd1,
    SEQ_COPY  = 2'd2
  } seq_state_e;

  localparam int unsigned XFER_BIT = 9;
endpackage

// File: rtl/safeload_slots.sv
module safeload_slots #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 26,
  parameter int unsigned SEL_W     = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [SEL_W-1:0]                  wr_sel_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [NUM_SLOTS-1:0]              clr_i,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  addr_o,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0]  data_o,
  output logic [NUM_SLOTS-1:0]              dirty_o
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en_i && (wr_sel_i == SEL_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        addr_o[g]  <= '0;
        data_o[g]  <= '0;
        dirty_o[g] <= 1'b0;
      end else begin
        if (hit) begin
          addr_o[g]  <= wr_addr_i;
          data_o[g]  <= wr_data_i;
          dirty_o[g] <= 1'b1;
        end else if (clr_i[g]) begin
          dirty_o[g] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/safeload_pick.sv
module safeload_pick #(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned SEL_W     = 3
) (
  input  logic [NUM_SLOTS-1:0] req_i,
  output logic                 any_o,
  output logic                 rest_any_o,
  output logic [SEL_W-1:0]     idx_o,
  output logic [NUM_SLOTS-1:0] onehot_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = SEL_W'(i);
    end
  end

  assign any_o      = |req_i;
  assign onehot_o   = req_i & ~(req_i - NUM_SLOTS'(1));
  assign rest_any_o = |(req_i & ~onehot_o);
endmodule

// File: rtl/safeload_seq.sv
module safeload_seq
  import safeload_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       xfer_req_i,
  input  logic       frame_sync_i,
  input  logic       any_dirty_i,
  input  logic       rest_any_i,
  output seq_state_e state_o,
  output logic       busy_o,
  output logic       copy_o,
  output logic       done_set_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    done_set_o = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (xfer_req_i) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (frame_sync_i) begin
          if (any_dirty_i) begin
            state_d = SEQ_COPY;
          end else begin
            state_d    = SEQ_IDLE;
            done_set_o = 1'b1;
          end
        end
      end
      SEQ_COPY: begin
        if (!rest_any_i) begin
          state_d    = SEQ_IDLE;
          done_set_o = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != SEQ_IDLE);
  assign copy_o  = (state_q == SEQ_COPY) && any_dirty_i;
endmodule

// File: rtl/safeload_status.sv
module safeload_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    done_o <= 1'b0;
    else if (set_i) done_o <= 1'b1;
    else if (rd_i)  done_o <= 1'b0;
  end
endmodule

// File: rtl/safeload_ctrl.sv
module safeload_ctrl
  import safeload_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 26,
  parameter int unsigned CTRL_W    = 12,
  localparam int unsigned SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_we_i,
  input  logic [SEL_W-1:0]  slot_sel_i,
  input  logic [ADDR_W-1:0] slot_addr_i,
  input  logic [DATA_W-1:0] slot_data_i,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              frame_sync_i,
  input  logic              stat_re_i,
  output logic              done_o,
  output logic              busy_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [DATA_W-1:0] ram_data_o
);
  logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slot_data;
  logic [NUM_SLOTS-1:0]             dirty;
  logic [NUM_SLOTS-1:0]             pick_oh;
  logic [NUM_SLOTS-1:0]             clr;
  logic [SEL_W-1:0]                 pick_idx;
  logic                             any_dirty, rest_any;
  logic                             xfer_req, copy, done_set;
  seq_state_e                       state;
  logic                             unused_ctrl;

  assign xfer_req    = ctrl_we_i && ctrl_wdata_i[XFER_BIT];
  assign unused_ctrl = ^{ctrl_wdata_i[CTRL_W-1:XFER_BIT+1], ctrl_wdata_i[XFER_BIT-1:0], pick_idx};

  safeload_slots #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) u_slots (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (slot_we_i && !busy_o),
    .wr_sel_i (slot_sel_i),
    .wr_addr_i(slot_addr_i),
    .wr_data_i(slot_data_i),
    .clr_i    (clr),
    .addr_o   (slot_addr),
    .data_o   (slot_data),
    .dirty_o  (dirty)
  );

  safeload_pick #(.NUM_SLOTS(NUM_SLOTS), .SEL_W(SEL_W)) u_pick (
    .req_i     (dirty),
    .any_o     (any_dirty),
    .rest_any_o(rest_any),
    .idx_o     (pick_idx),
    .onehot_o  (pick_oh)
  );

  safeload_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .xfer_req_i  (xfer_req),
    .frame_sync_i(frame_sync_i),
    .any_dirty_i (any_dirty),
    .rest_any_i  (rest_any),
    .state_o     (state),
    .busy_o      (busy_o),
    .copy_o      (copy),
    .done_set_o  (done_set)
  );

  safeload_status u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (done_set),
    .rd_i  (stat_re_i),
    .done_o(done_o)
  );

  assign clr      = copy ? pick_oh : '0;
  assign ram_we_o = copy;

  // AND-OR mux on the one-hot pick keeps index range clean
  always_comb begin
    ram_addr_o = '0;
    ram_data_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      ram_addr_o |= slot_addr[i] & {ADDR_W{pick_oh[i]}};
      ram_data_o |= slot_data[i] & {DATA_W{pick_oh[i]}};
    end
  end
endmodule

// File: rtl/safeload_ctrl_chk.sv
module safeload_ctrl_chk
  import safeload_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 5,
  parameter int unsigned CTRL_W    = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctrl_we_i,
  input logic [CTRL_W-1:0]    ctrl_wdata_i,
  input logic                 frame_sync_i,
  input logic                 stat_re_i,
  input logic                 done_o,
  input logic                 busy_o,
  input logic                 ram_we_o,
  input logic [NUM_SLOTS-1:0] dirty,
  input logic                 done_set,
  input seq_state_e           state
);
  a_r2_busy_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ctrl_we_i && ctrl_wdata_i[XFER_BIT]) |=> busy_o);

  a_r3_copy_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SEQ_COPY && $past(state) == SEQ_ARMED) |-> $past(frame_sync_i));

  a_r4_write_only_in_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (state == SEQ_COPY));

  a_r5_one_slot_retired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |=> ($countones(dirty) + 1 == $countones($past(dirty))));

  a_r6_done_rise_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !busy_o);

  a_r8_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_re_i && !done_set) |=> !done_o);

  a_r9_armed_dirty_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SEQ_ARMED) |=> $stable(dirty));
endmodule

bind safeload_ctrl safeload_ctrl_chk #(.NUM_SLOTS(NUM_SLOTS), .CTRL_W(CTRL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_we_i   (ctrl_we_i),
  .ctrl_wdata_i(ctrl_wdata_i),
  .frame_sync_i(frame_sync_i),
  .stat_re_i   (stat_re_i),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .ram_we_o    (ram_we_o),
  .dirty       (dirty),
  .done_set    (done_set),
  .state       (state)
);

// File: tb/safeload_ctrl_tb_top.sv
`timescale 1ns/1ps
module safeload_ctrl_tb_top;
  localparam int NS = 5;
  localparam int AW = 10;
  localparam int DW = 26;
  localparam int CW = 12;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          slot_we_i = 1'b0;
  logic [2:0]    slot_sel_i = '0;
  logic [AW-1:0] slot_addr_i = '0;
  logic [DW-1:0] slot_data_i = '0;
  logic          ctrl_we_i = 1'b0;
  logic [CW-1:0] ctrl_wdata_i = '0;
  logic          frame_sync_i = 1'b0;
  logic          stat_re_i = 1'b0;
  logic          done_o, busy_o, ram_we_o;
  logic [AW-1:0] ram_addr_o;
  logic [DW-1:0] ram_data_o;

  int total = 0;
  int bad = 0;

  logic [AW-1:0] m_addr [NS];
  logic [DW-1:0] m_data [NS];
  logic          m_dirty[NS];
  logic          m_busy;

  always #10 clk_i = ~clk_i;

  safeload_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .slot_we_i(slot_we_i), .slot_sel_i(slot_sel_i),
    .slot_addr_i(slot_addr_i), .slot_data_i(slot_data_i),
    .ctrl_we_i(ctrl_we_i), .ctrl_wdata_i(ctrl_wdata_i),
    .frame_sync_i(frame_sync_i), .stat_re_i(stat_re_i),
    .done_o(done_o), .busy_o(busy_o), .ram_we_o(ram_we_o),
    .ram_addr_o(ram_addr_o), .ram_data_o(ram_data_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) begin
      m_dirty[i] = 1'b0;
      m_addr[i]  = '0;
      m_data[i]  = '0;
    end
    m_busy = 1'b0;
  endtask

  task automatic host_write(input int sel, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk_i);
    slot_we_i = 1'b1; slot_sel_i = 3'(sel); slot_addr_i = a; slot_data_i = d;
    @(posedge clk_i); #1;
    slot_we_i = 1'b0;
    if (!m_busy && sel < NS) begin
      m_addr[sel] = a; m_data[sel] = d; m_dirty[sel] = 1'b1;
    end
  endtask

  task automatic request(input logic with_frame);
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = CW'(1) << 9; frame_sync_i = with_frame;
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0; frame_sync_i = 1'b0;
    m_busy = 1'b1;
  endtask

  task automatic read_status();
    @(negedge clk_i);
    stat_re_i = 1'b1;
    @(posedge clk_i); #1;
    stat_re_i = 1'b0;
    chk("R8 done cleared by read", 64'(done_o), 64'd0);
  endtask

  // frame strobe, then check the whole burst against the model
  task automatic do_copy();
    int n = 0;
    int sel_l[NS];
    for (int i = 0; i < NS; i++) if (m_dirty[i]) begin sel_l[n] = i; n++; end
    @(negedge clk_i);
    frame_sync_i = 1'b1;
    @(posedge clk_i); #1;
    frame_sync_i = 1'b0;
    for (int k = 0; k < n; k++) begin
      chk("R4 write enable", 64'(ram_we_o), 64'd1);
      chk("R4 write addr", 64'(ram_addr_o), 64'(m_addr[sel_l[k]]));
      chk("R4 write data", 64'(ram_data_o), 64'(m_data[sel_l[k]]));
      chk("R6 done low mid burst", 64'(done_o), 64'd0);
      @(posedge clk_i); #1;
    end
    if (n == 0) chk("R7 empty request done at frame", 64'(done_o), 64'd1);
    else        chk("R6 done after last write", 64'(done_o), 64'd1);
    chk("R6 busy low at end", 64'(busy_o), 64'd0);
    chk("R5 no extra write", 64'(ram_we_o), 64'd0);
    for (int i = 0; i < NS; i++) m_dirty[i] = 1'b0;
    m_busy = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 busy after reset", 64'(busy_o), 64'd0);
    chk("R10 done after reset", 64'(done_o), 64'd0);
    chk("R10 ram_we after reset", 64'(ram_we_o), 64'd0);
  endtask

  task automatic t_sparse();
    host_write(3, 10'h123, 26'h2ABCDEF);
    host_write(1, 10'h3FF, 26'h0000001);
    host_write(4, 10'h001, 26'h3FFFFFF);
    request(1'b0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk_i); #1;
      chk("R3 no write before frame", 64'(ram_we_o), 64'd0);
      chk("R2 busy while armed", 64'(busy_o), 64'd1);
    end
    do_copy();
    read_status();
  endtask

  task automatic t_rerequest();
    request(1'b0);
    do_copy(); // R5 R7: nothing pending
    read_status();
  endtask

  task automatic t_frame_same_cycle();
    host_write(0, 10'h055, 26'h1555555);
    request(1'b1);
    chk("R3 same-cycle strobe busy", 64'(busy_o), 64'd1);
    chk("R3 same-cycle strobe no write", 64'(ram_we_o), 64'd0);
    @(posedge clk_i); #1;
    chk("R3 still waiting", 64'(ram_we_o), 64'd0);
    do_copy();
    read_status();
  endtask

  task automatic t_ignored();
    @(negedge clk_i);
    ctrl_we_i = 1'b1; ctrl_wdata_i = 12'hDFF;
    @(posedge clk_i); #1;
    ctrl_we_i = 1'b0; ctrl_wdata_i = '0;
    chk("R2 bit9 clear no request", 64'(busy_o), 64'd0);
    host_write(6, 10'h2AA, 26'h0AAAAAA);
    host_write(5, 10'h2AB, 26'h0AAAAAB);
    request(1'b0);
    do_copy(); // R1: out-of-range selects produce no write
    read_status();
  endtask

  task automatic t_busy_write();
    host_write(2, 10'h0F0, 26'h00F0F0F);
    request(1'b0);
    host_write(0, 10'h111, 26'h1111111);
    chk("R9 busy during held-off write", 64'(busy_o), 64'd1);
    do_copy();
    read_status();
    request(1'b0);
    do_copy(); // R9: held-off write left nothing pending
    read_status();
  endtask

  task automatic t_overwrite_all();
    host_write(2, 10'h010, 26'h0000010);
    host_write(2, 10'h020, 26'h0000020); // R1 replace
    for (int i = 0; i < NS; i++) if (i != 2) host_write(i, AW'(10'h300 + i), DW'(26'h1000000 + i * 7));
    request(1'b0);
    do_copy();
    read_status();
  endtask

  task automatic t_set_wins();
    request(1'b0);
    @(negedge clk_i);
    frame_sync_i = 1'b1; stat_re_i = 1'b1;
    @(posedge clk_i); #1;
    frame_sync_i = 1'b0; stat_re_i = 1'b0;
    m_busy = 1'b0;
    chk("R8 set wins over read", 64'(done_o), 64'd1);
    chk("R7 busy low after empty", 64'(busy_o), 64'd0);
    read_status();
  endtask

  task automatic t_reset_mid();
    host_write(1, 10'h0AA, 26'h0BBBBBB);
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    model_clear();
    t_reset();
    request(1'b0);
    do_copy(); // R10: reset dropped the pending slot
    read_status();
  endtask

  initial begin
    model_clear();
    repeat (3) @(posedge clk_i);
    #1;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_sparse();
    t_rerequest();
    t_frame_same_cycle();
    t_ignored();
    t_busy_write();
    t_overwrite_all();
    t_set_wins();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule